// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog timer whose 16-bit control register is guarded against stray writes. All software access goes through one synchronous write port. A new control word is accepted only when a two-word unlock key comes directly before it. That rule covers turning the watchdog off as well as on. Reloading the counter needs a separate two-word service key. A plain write, a lone key word, or a key that is broken part-way through changes nothing.

While the watchdog is enabled, the counter advances once for each prescaled tick. The timeout is a power of two, chosen by a one-hot field in the control word. When the counter reaches the selected limit, the block raises a reset request. The request stays high until the block's own reset. The stored control word is always visible on a read-back output.

Top module: `wdk_watchdog`

## Requirements
- R1: After rst_n is low, ctrl_q reads 0x0000, wdt_reset is low, the watchdog is disabled and the key sequencer is idle.
- R2: A control update needs three writes in a row: 0x3333, then 0xCCCC, then the new word. The third write is stored in ctrl_q whatever its value.
- R3: While a key is in progress, any write other than the expected next key word sends the sequencer back to idle. That word is discarded and does not start a new sequence. A write made while idle that is not the first word of a key is also discarded.
- R4: Writing 0xAAAA and then 0x5555 as the next write clears the counter to zero.
- R5: The watchdog is enabled only when ctrl_q bits 15 and 14 are both 1. With any other value of those bits (for example 0x4080 or 0x8002), ticks are not counted.
- R6: Timeout field bits TAP_COUNT..1: bit k selects a limit of 2^(TAP_BASE+k-1) ticks. If several bits are set, the lowest one wins. If none is set, the longest limit is used.
- R7: While the watchdog is enabled, wdt_reset rises on the clock edge that registers the limit-th tick since the last reload.
- R8: An accepted control update also clears the counter to zero.
- R9: Once wdt_reset is high it stays high, and the counter stops, until rst_n. A service key does not clear it.
- R10: Data presented while wr_en is low is ignored. When a reload and a tick occur in the same cycle, the reload wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable, one cycle per tick |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 16 | Key or control word |
| wdt_reset | output | 1 | Sticky reset request |
| ctrl_q | output | 16 | Read-back of the control register |

## Verification
The bench builds the block with TAP_BASE = 3 and TAP_COUNT = 4, so the four selectable limits are 8, 16, 32 and 64 ticks. At these values every timeout, including the longest default, expires within a few dozen cycles. This makes exact expiry cycles, lowest-bit priority, the empty field, and reload-against-tick collisions cheap to exercise. The stored control word and the reset request are compared against a behavioural model on every clock.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam logic [15:0] CFG_KEY_A = 16'h3333;
  localparam logic [15:0] CFG_KEY_B = 16'hCCCC;
  localparam logic [15:0] SVC_KEY_A = 16'hAAAA;
  localparam logic [15:0] SVC_KEY_B = 16'h5555;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CFG1 = 2'd1,
    SEQ_CFG2 = 2'd2,
    SEQ_SVC1 = 2'd3
  } wdk_seq_e;

  // both enable bits must be set
  function automatic logic word_enables(input logic [15:0] w);
    return w[15] & w[14];
  endfunction

  // index of the lowest set timeout bit (bit idx+1); none set -> longest
  function automatic int unsigned tap_index(input logic [15:0] w,
                                            input int unsigned count);
    int unsigned idx;
    idx = count - 1;
    for (int i = 13; i >= 0; i--) begin
      if (i < int'(count) && w[i+1]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/wdk_key_seq.sv
module wdk_key_seq
  import wdk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        commit_o,
  output logic        service_o
);

  wdk_seq_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    commit_o  = 1'b0;
    service_o = 1'b0;
    if (wr_en) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (wr_data == CFG_KEY_A)      state_d = SEQ_CFG1;
          else if (wr_data == SVC_KEY_A) state_d = SEQ_SVC1;
          else                           state_d = SEQ_IDLE;
        end
        SEQ_CFG1: state_d = (wr_data == CFG_KEY_B) ? SEQ_CFG2 : SEQ_IDLE;
        SEQ_CFG2: begin
          commit_o = 1'b1;
          state_d  = SEQ_IDLE;
        end
        SEQ_SVC1: begin
          service_o = (wr_data == SVC_KEY_B);
          state_d   = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R10: idle bus leaves the sequencer where it was
  a_r10_idle_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q));

  // R3: wrong second unlock word falls back to idle
  a_r3_break_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state_q == SEQ_CFG1 && wr_data != CFG_KEY_B) |=> state_q == SEQ_IDLE);

  // R2: a commit is always followed by idle
  a_r2_commit_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> state_q == SEQ_IDLE);

endmodule

// File: rtl/wdk_ctrl_reg.sv
module wdk_ctrl_reg
  import wdk_pkg::*;
#(
  parameter int unsigned TAP_COUNT = 8,
  localparam int unsigned TAP_IW = (TAP_COUNT > 1) ? $clog2(TAP_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [15:0]       data_i,
  output logic [15:0]       ctrl_o,
  output logic              enabled_o,
  output logic [TAP_IW-1:0] tap_o
);

  logic [15:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (commit_i) ctrl_q <= data_i;
  end

  assign ctrl_o    = ctrl_q;
  assign enabled_o = word_enables(ctrl_q);
  assign tap_o     = TAP_IW'(tap_index(ctrl_q, TAP_COUNT));

  // R2: the register only moves on a keyed commit
  a_r2_ctrl_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(commit_i));

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int unsigned TAP_BASE  = 24,
  parameter int unsigned TAP_COUNT = 8,
  localparam int unsigned TAP_IW = (TAP_COUNT > 1) ? $clog2(TAP_COUNT) : 1,
  localparam int unsigned CNT_W  = TAP_BASE + TAP_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              enable_i,
  input  logic              reload_i,
  input  logic [TAP_IW-1:0] tap_i,
  output logic              expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             advance;
  logic             hit;

  assign limit   = {{(CNT_W-1){1'b0}}, 1'b1} << (TAP_BASE + int'(tap_i));
  assign advance = tick_i && enable_i && !expired_o && !reload_i;
  assign hit     = advance && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else begin
      if (reload_i)     cnt_q <= '0;
      else if (advance) cnt_q <= cnt_q + 1'b1;
      if (hit) expired_o <= 1'b1;
    end
  end

  // R4/R8: any reload leaves a zero count
  a_r4_reload_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> cnt_q == '0);

  // R5: a disabled watchdog does not count
  a_r5_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !reload_i) |=> $stable(cnt_q));

  // R7: the count never passes the selected limit
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R9: expiry is sticky and stops the counter
  a_r9_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |=> expired_o);
  a_r9_count_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !reload_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog #(
  parameter int unsigned TAP_BASE  = 24,
  parameter int unsigned TAP_COUNT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        wdt_reset,
  output logic [15:0] ctrl_q
);

  localparam int unsigned TAP_IW = (TAP_COUNT > 1) ? $clog2(TAP_COUNT) : 1;

  logic              commit;
  logic              service;
  logic              reload;
  logic              enabled;
  logic [TAP_IW-1:0] tap;

  wdk_key_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .commit_o  (commit),
    .service_o (service)
  );

  wdk_ctrl_reg #(.TAP_COUNT(TAP_COUNT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .data_i    (wr_data),
    .ctrl_o    (ctrl_q),
    .enabled_o (enabled),
    .tap_o     (tap)
  );

  assign reload = commit | service;

  wdk_counter #(.TAP_BASE(TAP_BASE), .TAP_COUNT(TAP_COUNT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .enable_i  (enabled),
    .reload_i  (reload),
    .tap_i     (tap),
    .expired_o (wdt_reset)
  );

  // R5: a request only rises out of an enabled state
  a_r5_rise_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> $past(enabled));

  // R4: service and commit are never the same write
  a_r4_one_reload_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, service}));

endmodule

// File: tb/wdk_watchdog_tb_top.sv
`timescale 1ns/1ps
module wdk_watchdog_tb_top;

  localparam int TB = 3;
  localparam int TC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wdt_reset;
  logic [15:0] ctrl_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdk_watchdog #(.TAP_BASE(TB), .TAP_COUNT(TC)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .wdt_reset(wdt_reset), .ctrl_q(ctrl_q)
  );

  // behavioural reference
  int          m_state;
  logic [15:0] m_ctrl;
  int          m_cnt;
  bit          m_exp;

  function automatic int m_limit(input logic [15:0] c);
    int e;
    e = TB + TC - 1;
    for (int k = TC; k >= 1; k--) if (c[k]) e = TB + k - 1;
    return 1 << e;
  endfunction

  always @(posedge clk) begin
    bit rl;
    if (!rst_n) begin
      m_state = 0; m_ctrl = '0; m_cnt = 0; m_exp = 0;
    end else begin
      rl = 0;
      if (wr_en) begin
        case (m_state)
          0: m_state = (wr_data == 16'h3333) ? 1 : (wr_data == 16'hAAAA) ? 3 : 0;
          1: m_state = (wr_data == 16'hCCCC) ? 2 : 0;
          2: begin m_ctrl = wr_data; rl = 1; m_state = 0; end
          default: begin rl = (wr_data == 16'h5555); m_state = 0; end
        endcase
      end
      if (rl) m_cnt = 0;
      else if (tick && m_ctrl[15] && m_ctrl[14] && !m_exp) begin
        m_cnt++;
        if (m_cnt == m_limit(m_ctrl)) m_exp = 1;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(32'(ctrl_q), 32'(m_ctrl), "R2 model ctrl_q");
      chk(32'(wdt_reset), 32'(m_exp), "R7 model wdt_reset");
    end
  end

  task automatic cyc(input logic e, input logic [15:0] d, input logic t);
    wr_en = e; wr_data = d; tick = t;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 16'h0, 0);
    cyc(0, 16'h0, 0);
    rst_n = 1'b1;
    cyc(0, 16'h0, 0);
  endtask

  task automatic key_write(input logic [15:0] c);
    cyc(1, 16'h3333, 0);
    cyc(1, 16'hCCCC, 0);
    cyc(1, c, 0);
    cyc(0, 16'h0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 1);
  endtask

  task automatic service();
    cyc(1, 16'hAAAA, 0);
    cyc(1, 16'h5555, 0);
    cyc(0, 16'h0, 0);
  endtask

  task automatic measure(input logic [15:0] c, input int exp, input string what);
    int n;
    do_reset();
    key_write(c);
    n = 0;
    while (!wdt_reset && n < 200) begin
      cyc(0, 16'h0, 1);
      n++;
    end
    chk(32'(n), 32'(exp), what);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog expired act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(32'(ctrl_q), 32'h0, "R1 ctrl_q after reset");
    chk(32'(wdt_reset), 32'h0, "R1 wdt_reset after reset");
    ticks(20);
    chk(32'(wdt_reset), 32'h0, "R1 disabled out of reset");

    // R3 plain write and broken key are discarded
    cyc(1, 16'hC002, 0);
    cyc(1, 16'h3333, 0); cyc(1, 16'hAAAA, 0); cyc(1, 16'hCCCC, 0); cyc(1, 16'hC002, 0);
    cyc(0, 16'h0, 0);
    chk(32'(ctrl_q), 32'h0, "R3 broken key leaves ctrl");

    // R2/R5 disable word
    key_write(16'h4080);
    chk(32'(ctrl_q), 32'h4080, "R2 keyed write stored");
    ticks(80);
    chk(32'(wdt_reset), 32'h0, "R5 0x4080 disabled");
    key_write(16'h8002);
    ticks(20);
    chk(32'(wdt_reset), 32'h0, "R5 only bit15 disabled");

    // R4/R7/R9 service, broken service, exact expiry
    key_write(16'hC002);
    ticks(7);
    chk(32'(wdt_reset), 32'h0, "R7 seven of eight ticks");
    service();
    ticks(7);
    chk(32'(wdt_reset), 32'h0, "R4 service reloads");
    cyc(1, 16'hAAAA, 0); cyc(1, 16'h1234, 0); cyc(1, 16'h5555, 0);
    cyc(0, 16'h0, 0);
    ticks(1);
    chk(32'(wdt_reset), 32'h1, "R3 broken service ignored, R7 expiry");
    service();
    ticks(3);
    chk(32'(wdt_reset), 32'h1, "R9 sticky through service");
    do_reset();
    chk(32'(wdt_reset), 32'h0, "R9 cleared by rst_n");

    // R6 tap selection
    measure(16'hC002, 8,  "R6 bit1 limit");
    measure(16'hC004, 16, "R6 bit2 limit");
    measure(16'hC010, 64, "R6 bit4 limit");
    measure(16'hC00A, 8,  "R6 lowest bit wins");
    measure(16'hC000, 64, "R6 empty field longest");

    // R8 commit reloads
    do_reset();
    key_write(16'hC002);
    ticks(6);
    key_write(16'hC002);
    n = 0;
    while (!wdt_reset && n < 200) begin cyc(0, 16'h0, 1); n++; end
    chk(32'(n), 32'd8, "R8 commit clears counter");

    // R10 idle bus ignored, reload beats tick
    do_reset();
    key_write(16'hC002);
    ticks(5);
    cyc(0, 16'h3333, 0); cyc(0, 16'hCCCC, 0); cyc(0, 16'h0000, 0);
    chk(32'(ctrl_q), 32'hC002, "R10 data without wr_en ignored");
    cyc(1, 16'hCCCC, 0); cyc(1, 16'h0000, 0);
    chk(32'(ctrl_q), 32'hC002, "R10 no stale key state");
    cyc(1, 16'hAAAA, 0);
    cyc(1, 16'h5555, 1);
    ticks(7);
    chk(32'(wdt_reset), 32'h0, "R10 reload wins over tick");
    ticks(1);
    chk(32'(wdt_reset), 32'h1, "R10 expiry after full window");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule